// File: doc/BRIEF.md
# Serial Wiper Register Controller

This block is the digital core of a 128-step digital potentiometer. A host writes a wiper code over three plain serial pins: an active-low select, a serial clock and a data line. The block samples these pins with its own system clock. A shift register collects the bits, and a wiper latch takes the collected word when the select pin rises. The latched code is decoded into a one-hot tap select for the resistor ladder, plus a control for the top-terminal switch and a control for the bottom-terminal switch. The analog ladder lies outside the block.

The serial output is an open-drain style pull-down enable. It repeats each bit seven shift clocks after that bit entered, so several devices can be chained with every device's output wired to the next device's input. A low level on the preset input forces the latch to midscale and clears the output bit. A low level on the sleep input opens the top switch, parks the wiper on the bottom terminal and releases the serial output. The serial port keeps working while the block sleeps, so a preset can be written and takes effect on wake-up.

There is no valid/ready stream at this edge. The host paces each transfer through the serial clock, so the block never applies back-pressure. The host must keep each serial clock level for at least four system clocks.

Top module: `wiper_serial_ctrl`

## Requirements
- R1: While sd_cs_n is low, each rising sd_clk shifts sd_in into the shift register with the MSB sent first. When sd_cs_n rises, the last 7 bits are loaded onto wiper_code.
- R2: Rising sd_clk edges while sd_cs_n is high shift nothing. A select pulse with no clocks reloads the word that is already held, and sdo_pull_low does not change.
- R3: wiper_code changes only on a rising sd_cs_n. In the cycle after a load it equals the shift register contents at the moment of the load.
- R4: In a frame longer than 7 bits, the leading extra bits are dropped, and the final 7 bits form the code.
- R5: After each shift, the serial output bit is the bit that entered 7 shifts earlier. sdo_pull_low is 1 (pull the pin low) when that bit is 0 and the block is awake. It is 0 (pin released) otherwise.
- R6: While preset_n is low, wiper_code is 0x40 and the shift register and output bit are 0. When awake, sdo_pull_low is therefore 1.
- R7: preset_n low overrides a rising sd_cs_n that arrives at the same time, and wiper_code stays at 0x40.
- R8: While awake, tap_sel has exactly bit wiper_code set (bit 0 is the bottom terminal, bit 127 is one step below the top). top_sw_on is 1, and bot_sw_on is 1 only for code 0x00.
- R9: While sleep_n is low, top_sw_on is 0, tap_sel is exactly bit 0, bot_sw_on is 1 and sdo_pull_low is 0.
- R10: While asleep, a serial write still updates wiper_code. When sleep_n rises, tap_sel follows the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| preset_n | input | 1 | Asynchronous active-low reset that sets the wiper to midscale |
| sleep_n | input | 1 | Active-low shutdown control |
| sd_cs_n | input | 1 | Serial select, active low; its rising edge loads the wiper |
| sd_clk | input | 1 | Serial shift clock; rising edges shift |
| sd_in | input | 1 | Serial data in, MSB first |
| sdo_pull_low | output | 1 | Pull-down enable for the chained serial output |
| wiper_code | output | 7 | Latched wiper code |
| tap_sel | output | 128 | One-hot ladder tap select |
| top_sw_on | output | 1 | Closes the top-terminal switch |
| bot_sw_on | output | 1 | Closes the bottom-terminal switch |

## Verification
Some rules are checked by assertions on every cycle. The tap select must always be one-hot. Sleep must force the parked state and release the serial output. The shift register and the output bit must hold when no shift edge occurs. The latch must move only on a load, and only to the shifted word. Other behaviour can only be shown by the bench scenarios: all 128 codes written and decoded, and the seven-shift delay on the output across back-to-back frames. The bench also covers an over-long frame, clocks sent while deselected, a preset written during sleep, and reset colliding with a load.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
  } serial_pins_t;

  localparam serial_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};
endpackage

// File: rtl/wsc_pin_sync.sv
module wsc_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage[g] <= RST_VAL;
        else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wsc_frame_ctrl.sv
module wsc_frame_ctrl (
  input  logic               clk,
  input  logic               rst_n,
  input  wsc_pkg::serial_pins_t pins,
  output logic               shift_en,
  output logic               load,
  output logic               din
);
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pins.sck;
      cs_d  <= pins.cs_n;
    end

  assign shift_en = pins.sck & ~sck_d & ~pins.cs_n;
  assign load     = pins.cs_n & ~cs_d;
  assign din      = pins.sdi;

  a_r2_shift_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !pins.cs_n);
endmodule

// File: rtl/wsc_shift_chain.sv
module wsc_shift_chain #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [CODE_W-1:0] word,
  output logic              out_bit
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word    <= '0;
      out_bit <= 1'b0;
    end else if (shift_en) begin
      word    <= {word[CODE_W-2:0], din};
      out_bit <= word[CODE_W-1];
    end

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word) && $stable(out_bit));
endmodule

// File: rtl/wsc_wiper_latch.sv
module wsc_wiper_latch #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] word_in,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    code <= MIDSCALE;
    else if (load) code <= word_in;

  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code));
endmodule

// File: rtl/wsc_tap_decode.sv
module wsc_tap_decode #(
  parameter int CODE_W = 7,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              awake,
  output logic [TAPS-1:0]   tap_sel,
  output logic              top_on,
  output logic              bot_on
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_bottom
      assign tap_sel[i] = ~awake | (code == '0);
    end else begin : g_upper
      assign tap_sel[i] = awake & (code == CODE_W'(i));
    end
  end

  assign top_on = awake;
  assign bot_on = tap_sel[0];
endmodule

// File: rtl/wiper_serial_ctrl.sv
module wiper_serial_ctrl #(
  parameter int CODE_W = 7,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              preset_n,
  input  logic              sleep_n,
  input  logic              sd_cs_n,
  input  logic              sd_clk,
  input  logic              sd_in,
  output logic              sdo_pull_low,
  output logic [CODE_W-1:0] wiper_code,
  output logic [TAPS-1:0]   tap_sel,
  output logic              top_sw_on,
  output logic              bot_sw_on
);
  import wsc_pkg::*;

  serial_pins_t pins_raw, pins_s;
  logic shift_en, load, din, out_bit;
  logic [CODE_W-1:0] sr_word;

  assign pins_raw = '{cs_n: sd_cs_n, sck: sd_clk, sdi: sd_in};

  wsc_pin_sync #(.W($bits(serial_pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(preset_n), .d(pins_raw), .q(pins_s));

  wsc_frame_ctrl u_frame (
    .clk(clk), .rst_n(preset_n), .pins(pins_s),
    .shift_en(shift_en), .load(load), .din(din));

  wsc_shift_chain #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(preset_n), .shift_en(shift_en), .din(din),
    .word(sr_word), .out_bit(out_bit));

  wsc_wiper_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(preset_n), .load(load), .word_in(sr_word), .code(wiper_code));

  wsc_tap_decode #(.CODE_W(CODE_W)) u_dec (
    .code(wiper_code), .awake(sleep_n), .tap_sel(tap_sel),
    .top_on(top_sw_on), .bot_on(bot_sw_on));

  assign sdo_pull_low = sleep_n & ~out_bit;

  a_r3_load_takes_word: assert property (@(posedge clk) disable iff (!preset_n)
    load |=> wiper_code == $past(sr_word));
  a_r8_tap_onehot: assert property (@(posedge clk) disable iff (!preset_n)
    $countones(tap_sel) == 1);
  a_r9_sleep_parks: assert property (@(posedge clk) disable iff (!preset_n)
    !sleep_n |-> (!top_sw_on && tap_sel[0] && bot_sw_on && !sdo_pull_low));
endmodule

// File: tb/wiper_serial_ctrl_tb.sv
module wiper_serial_ctrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic preset_n, sleep_n, sd_cs_n, sd_clk, sd_in;
  logic sdo_pull_low, top_sw_on, bot_sw_on;
  logic [6:0] wiper_code;
  logic [127:0] tap_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] hist;

  wiper_serial_ctrl u_dut (
    .clk(clk), .preset_n(preset_n), .sleep_n(sleep_n), .sd_cs_n(sd_cs_n),
    .sd_clk(sd_clk), .sd_in(sd_in), .sdo_pull_low(sdo_pull_low),
    .wiper_code(wiper_code), .tap_sel(tap_sel), .top_sw_on(top_sw_on),
    .bot_sw_on(bot_sw_on));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serial_bit(input bit b);
    logic e;
    sd_in = b;
    wait_n(4);
    sd_clk = 1'b1;
    wait_n(4);
    hist = {hist[62:0], b};
    e = hist[7];
    // R5: output reflects the bit from seven shifts earlier
    chk(sdo_pull_low == (sleep_n & ~e), "R5 sdo", 128'(sdo_pull_low), 128'(sleep_n & ~e));
    sd_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    sd_cs_n = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) serial_bit(v[i]);
    sd_cs_n = 1'b1;
    wait_n(6);
  endtask

  task automatic chk_decode(input logic [6:0] c, input string req);
    logic [127:0] et;
    et = sleep_n ? (128'(1) << c) : 128'(1);
    chk(wiper_code == c, req, 128'(wiper_code), 128'(c));
    chk(tap_sel == et && top_sw_on == sleep_n && bot_sw_on == (!sleep_n || c == 7'd0),
        req, tap_sel, et);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev_sdo;
    preset_n = 1'b0; sleep_n = 1'b1; sd_cs_n = 1'b1; sd_clk = 1'b0; sd_in = 1'b0;
    hist = '0;
    wait_n(5);
    // R6: reset state
    chk_decode(7'h40, "R6 reset midscale");
    chk(sdo_pull_low == 1'b1, "R6 sdo cleared", 128'(sdo_pull_low), 128'(1));
    preset_n = 1'b1;
    wait_n(3);

    // R1 / R8: every code written and decoded
    for (int c = 0; c < 128; c++) begin
      frame(32'(c), 7);
      chk_decode(7'(c), "R1 R8 sweep");
    end

    // R4: 14-bit frame, last 7 bits kept (leading bits pass out, R5)
    frame({18'd0, 7'h55, 7'h2A}, 14);
    chk_decode(7'h2A, "R4 long frame");

    // R2: clocks while deselected do not shift
    prev_sdo = sdo_pull_low;
    sd_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_n(4); sd_clk = 1'b1; wait_n(4); sd_clk = 1'b0;
    end
    wait_n(4);
    sd_cs_n = 1'b0; wait_n(4); sd_cs_n = 1'b1; wait_n(6);
    chk(wiper_code == 7'h2A, "R2 no shift when deselected", 128'(wiper_code), 128'(7'h2A));
    chk(sdo_pull_low == prev_sdo, "R2 sdo held", 128'(sdo_pull_low), 128'(prev_sdo));
    // R3: latch holds without a select edge
    chk(wiper_code == 7'h2A, "R3 hold", 128'(wiper_code), 128'(7'h2A));

    // R9: sleep parks the wiper and releases sdo
    sleep_n = 1'b0;
    wait_n(1);
    chk_decode(7'h2A, "R9 sleep");
    chk(sdo_pull_low == 1'b0, "R9 sdo released", 128'(sdo_pull_low), 128'(0));

    // R10: preset written while asleep
    frame(32'h33, 7);
    chk_decode(7'h33, "R10 write in sleep");
    sleep_n = 1'b1;
    wait_n(1);
    chk_decode(7'h33, "R10 wake");

    // R7: reset collides with a load
    sd_cs_n = 1'b0;
    wait_n(4);
    for (int k = 0; k < 4; k++) serial_bit(1'b1);
    sd_cs_n = 1'b1;
    preset_n = 1'b0;
    wait_n(8);
    preset_n = 1'b1;
    hist = '0;
    wait_n(6);
    chk_decode(7'h40, "R7 reset beats load");
    chk(sdo_pull_low == 1'b1, "R6 sdo after reset", 128'(sdo_pull_low), 128'(1));

    // R5 after reset: first frame shifts out the cleared zeros
    frame(32'h7F, 7);
    chk_decode(7'h7F, "R1 top tap");
    frame(32'h00, 7);
    chk_decode(7'h00, "R8 bottom tap");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule